// File: doc/BRIEF.md
# Four-Times Linear Interpolation Upsampler

This block takes a stream of 12-bit real samples arriving at a base rate and produces a stream at four times that rate, 14 bits wide. Between each pair of successive real samples it places three predicted values. These come from two levels of two-point linear interpolation: a midpoint between the pair, then a midpoint on each side of it. The two extra bits carry the quarter-step fractions exactly, so none of the values is rounded.

When a real sample is accepted and an earlier one is held, all four output points for that pair are computed at once. They are registered together and then sent out on consecutive clocks behind a valid strobe. The earlier sample, padded with two zero bits on the right, is always the first point of its burst.

The caller must leave at least four clocks between input samples. A sample that arrives while a burst still has points left to send is dropped, and an overrun flag is raised for one cycle.

Top module: `lin_interp_x4`

## Requirements
- R1: After reset, up_valid_o and overrun_o are low and stay low until a second sample has been accepted.
- R2: The first sample accepted after reset is stored as history only, and no output point is produced for it.
- R3: Each later accepted sample causes up_valid_o to be high for exactly four consecutive cycles, starting in the cycle after the accepting clock edge.
- R4: For a held sample a and a newly accepted sample b, the four burst values are 4a, 3a+b, 2a+2b and a+3b, in that order.
- R5: The first value of every burst equals the held sample with two zero bits appended on its right.
- R6: All burst values are exact at the ends of the input range; for example a=4095 and b=4095 give 16380 four times.
- R7: Samples spaced exactly four clocks apart give an unbroken up_valid_o run with no idle cycle between bursts.
- R8: A sample presented while the current burst has one or more points still to send is dropped. It changes neither the history nor the running burst, and overrun_o is high for exactly the cycle after that edge.
- R9: When samples are spaced more than four clocks apart, up_valid_o is low in the cycles between bursts.
- R10: Each burst interpolates from the most recently accepted sample; a dropped sample never becomes the held sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | IN_W (12) | Input sample, unsigned |
| up_valid_o | output | 1 | Output point strobe |
| up_data_o | output | IN_W+UP_LOG2 (14) | Interpolated output point |
| overrun_o | output | 1 | One-cycle flag for a dropped early sample |

## Verification
The hardest case to reach is an early sample that lands on each of the three busy slots of a burst. Of these, the slot just before the seamless handover point, three clocks after acceptance, is the tightest. Directed sequences place an early sample one, two and three clocks after an accepted one. A long run with random spacing of one to six clocks then mixes early arrivals with exact four-clock handovers. Full-scale and zero pairs are driven on purpose to reach the top of the output range.

// File: rtl/lin_interp_pkg.sv
package lin_interp_pkg;
  localparam int unsigned IN_W_DEF    = 12;
  localparam int unsigned UP_LOG2_DEF = 2;

  function automatic int unsigned up_factor(input int unsigned up_log2);
    return 32'd1 << up_log2;
  endfunction
endpackage

// File: rtl/interp_hist.sv
module interp_hist #(
  parameter int unsigned IN_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [IN_W-1:0] data_i,
  output logic [IN_W-1:0] prev_o,
  output logic            have_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o <= '0;
      have_o <= 1'b0;
    end else if (load_i) begin
      prev_o <= data_i;
      have_o <= 1'b1;
    end
  end

  // R2
  hist_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_o |=> have_o);
endmodule

// File: rtl/interp_points.sv
module interp_points #(
  parameter int unsigned IN_W    = 12,
  parameter int unsigned UP_LOG2 = 2,
  localparam int unsigned UP     = 1 << UP_LOG2,
  localparam int unsigned OUT_W  = IN_W + UP_LOG2
) (
  input  logic [IN_W-1:0]           a_i,
  input  logic [IN_W-1:0]           b_i,
  output logic [UP-1:0][OUT_W-1:0]  pts_o
);
  logic [OUT_W-1:0] a_ext, b_ext;
  assign a_ext = {{UP_LOG2{1'b0}}, a_i};
  assign b_ext = {{UP_LOG2{1'b0}}, b_i};

  // point k = ((UP-k)*a + k*b), exact in OUT_W bits
  for (genvar k = 0; k < UP; k++) begin : g_pt
    localparam logic [OUT_W-1:0] WA = OUT_W'(UP - k);
    localparam logic [OUT_W-1:0] WB = OUT_W'(k);
    assign pts_o[k] = WA * a_ext + WB * b_ext;
  end
endmodule

// File: rtl/interp_seq.sv
module interp_seq #(
  parameter int unsigned OUT_W   = 14,
  parameter int unsigned UP_LOG2 = 2,
  localparam int unsigned UP     = 1 << UP_LOG2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [UP-1:0][OUT_W-1:0]  pts_i,
  output logic [OUT_W-1:0]          data_o,
  output logic                      valid_o,
  output logic                      busy_o
);
  logic [UP_LOG2-1:0]          rem_q;
  logic [UP-2:0][OUT_W-1:0]    pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      pend_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      data_o  <= pts_i[0];
      valid_o <= 1'b1;
      rem_q   <= UP_LOG2'(UP - 1);
      for (int k = 0; k < UP - 1; k++) pend_q[k] <= pts_i[k+1];
    end else if (rem_q != '0) begin
      data_o  <= pend_q[0];
      valid_o <= 1'b1;
      rem_q   <= rem_q - 1'b1;
      for (int k = 0; k < UP - 2; k++) pend_q[k] <= pend_q[k+1];
    end else begin
      valid_o <= 1'b0;
    end
  end

  assign busy_o = (rem_q != '0);

  // R3
  burst_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && data_o == $past(pts_i[0]));
  // R3
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));
  // R8
  busy_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> valid_o);
endmodule

// File: rtl/lin_interp_x4.sv
module lin_interp_x4
  import lin_interp_pkg::*;
#(
  parameter int unsigned IN_W     = IN_W_DEF,
  parameter int unsigned UP_LOG2  = UP_LOG2_DEF,
  localparam int unsigned UP      = 1 << UP_LOG2,
  localparam int unsigned OUT_W   = IN_W + UP_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [IN_W-1:0]  smp_data_i,
  output logic             up_valid_o,
  output logic [OUT_W-1:0] up_data_o,
  output logic             overrun_o
);
  logic [IN_W-1:0]          prev;
  logic                     have_prev, busy, accept, start;
  logic [UP-1:0][OUT_W-1:0] pts;

  assign accept = smp_valid_i && !busy;
  assign start  = accept && have_prev;

  interp_hist #(.IN_W(IN_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (smp_data_i),
    .prev_o (prev),
    .have_o (have_prev)
  );

  interp_points #(.IN_W(IN_W), .UP_LOG2(UP_LOG2)) u_pts (
    .a_i   (prev),
    .b_i   (smp_data_i),
    .pts_o (pts)
  );

  interp_seq #(.OUT_W(OUT_W), .UP_LOG2(UP_LOG2)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .pts_i   (pts),
    .data_o  (up_data_o),
    .valid_o (up_valid_o),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_o <= 1'b0;
    else         overrun_o <= smp_valid_i && busy;
  end

  // R2
  first_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !have_prev) |=> !up_valid_o);
  // R5
  pad_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> up_data_o == {$past(prev), {UP_LOG2{1'b0}}});
  // R8
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(smp_valid_i));
  // R10
  drop_keeps_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && busy) |=> $stable(prev) && overrun_o);
endmodule

// File: tb/sim_lin_interp_x4.sv
`timescale 1ns/1ps
module sim_lin_interp_x4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        up_valid, overrun;
  logic [13:0] up_data;

  int checks = 0, errors = 0;
  string phase = "R1 reset";

  lin_interp_x4 u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .up_valid_o(up_valid), .up_data_o(up_data), .overrun_o(overrun)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int exp_q[$];
  int prev_m;
  bit have_m, ovr_m, busy_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete(); have_m = 0; ovr_m = 0; prev_m = 0;
    end else begin
      busy_m = exp_q.size() > 1;
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      ovr_m = 0;
      if (smp_valid) begin
        if (busy_m) ovr_m = 1;
        else if (!have_m) begin have_m = 1; prev_m = int'(smp_data); end
        else begin
          for (int k = 0; k < 4; k++) exp_q.push_back((4 - k) * prev_m + k * int'(smp_data));
          prev_m = int'(smp_data);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual %0d expected %0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  bit run_chk = 0;
  always @(negedge clk) if (rst_n && run_chk) begin
    chk(up_valid === (exp_q.size() > 0), "R3 valid", int'(up_valid), int'(exp_q.size() > 0));
    chk(overrun === ovr_m, "R8 overrun", int'(overrun), int'(ovr_m));
    if (exp_q.size() > 0)
      chk(int'(up_data) == exp_q[0], "R4 data", int'(up_data), exp_q[0]);
  end

  task automatic send(input int val, input int gap);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 12'(val);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(up_valid === 1'b0, "R1 valid", int'(up_valid), 0);
    chk(overrun === 1'b0, "R1 overrun", int'(overrun), 0);
    run_chk = 1;

    phase = "R2 first sample";
    send(100, 6);
    chk(up_valid === 1'b0, "R2 no output", int'(up_valid), 0);

    phase = "R4 R5 single pair";
    send(200, 8);
    send(37, 8);

    phase = "R7 back-to-back";
    for (int i = 0; i < 8; i++) send(i * 500 + 3, 4);
    repeat (4) @(negedge clk);

    phase = "R8 R10 early at 1";
    send(1000, 1); send(4000, 3); send(1200, 6);
    phase = "R8 R10 early at 2";
    send(2000, 2); send(10, 2); send(2100, 6);
    phase = "R8 R10 early at 3";
    send(3000, 3); send(4095, 1); send(3300, 6);

    phase = "R6 range ends";
    send(4095, 4); send(4095, 4); send(0, 4); send(4095, 4); send(0, 6);

    phase = "R9 wide gap";
    send(1234, 9); send(2345, 9);
    chk(up_valid === 1'b0, "R9 idle", int'(up_valid), 0);

    phase = "R3 random spacing";
    for (int i = 0; i < 300; i++) send(int'($urandom_range(4095, 0)), int'($urandom_range(6, 1)));
    repeat (8) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule